// File: doc/BRIEF.md
# Chip-Select Gated Command Register

This block is a registered repeater for a DRAM address and command bus. On each rising clock edge it looks at the chip-select inputs. If any select taking part in gating is low, it captures the address, bank address and the three strobe lines (row strobe, column strobe, write enable) and re-drives them. If no such select is low, those outputs keep their previous values. Clock-enable and on-die-termination lines do not depend on chip select: they are registered and re-driven on every edge.

A mode input chooses between two-select operation, where only selects 0 and 1 count, and four-select operation, where selects 2 and 3 also gate and are re-driven. Every output exists as two identical copies, group A and group B. Each group has its own enable. A disabled group drives all zeros and reports a low per-group enable flag, so the block needs no internal tri-states. While reset is low, all state is cleared and both groups report disabled. Starting with the first clock edge after reset is released, the groups drive. The command and chip-select outputs stay low until the first access with a select asserted has been registered.

Top module: `cs_gated_cmd_reg`

## Requirements
- R1: While rst_ni is low, every output of both groups, including q_oe_o, is 0.
- R2: From the first rising edge after reset release, q_oe_o[g] equals grp_en_i[g]. The command outputs (address, bank, ras, cas, we) and q_cs_n_o stay 0 until an edge with an effective select low has been registered.
- R3: At a rising edge where at least one effective select is low, addr_i, ba_i, ras_n_i, cas_n_i and we_n_i are captured and appear on the command outputs right after that edge, with one cycle of latency.
- R4: At a rising edge where no effective select is low, the command outputs keep their previous values.
- R5: cke_i and odt_i are registered on every rising edge whatever the chip selects are, and appear on q_cke_o and q_odt_o after that edge.
- R6: With quad_cs_en_i = 0, cs_n_i[3:2] are ignored. A low on them neither captures a command nor marks the first access, and q_cs_n_o bits 3:2 read 1 once the outputs follow the selects.
- R7: With quad_cs_en_i = 1, a low on cs_n_i[2] or cs_n_i[3] captures a command and is re-driven on the matching q_cs_n_o bit.
- R8: After the first access, q_cs_n_o shows the effective selects sampled at the last rising edge, on every edge. Bit i corresponds to cs_n_i[i], active low.
- R9: When grp_en_i[g] = 0, all outputs of group g, including q_oe_o[g], are 0. The other group is not affected. The enable acts without a clock delay.
- R10: When both groups are enabled, they carry identical values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| quad_cs_en_i | input | 1 | 1 = all four selects gate, 0 = only selects 0 and 1 |
| grp_en_i | input | NGRP | Per-group output enable (bit 0 = group A, bit 1 = group B) |
| addr_i | input | ADDR_W | Address, gated |
| ba_i | input | BA_W | Bank address, gated |
| ras_n_i | input | 1 | Row strobe, gated |
| cas_n_i | input | 1 | Column strobe, gated |
| we_n_i | input | 1 | Write enable, gated |
| cs_n_i | input | CS_W | Chip selects, active low |
| cke_i | input | CKE_W | Clock enables, ungated |
| odt_i | input | ODT_W | On-die termination controls, ungated |
| q_oe_o | output | NGRP | Per-group drive flag |
| q_addr_o | output | NGRP x ADDR_W | Registered address per group |
| q_ba_o | output | NGRP x BA_W | Registered bank address per group |
| q_ras_n_o | output | NGRP | Registered row strobe per group |
| q_cas_n_o | output | NGRP | Registered column strobe per group |
| q_we_n_o | output | NGRP | Registered write enable per group |
| q_cs_n_o | output | NGRP x CS_W | Registered effective selects per group |
| q_cke_o | output | NGRP x CKE_W | Registered clock enables per group |
| q_odt_o | output | NGRP x ODT_W | Registered termination controls per group |

## Verification
The assertions assume that every input, including grp_en_i and quad_cs_en_i, is stable around the rising edge. They also assume that reset is asserted and released away from that edge. The stimulus meets this by changing every input only on the falling edge. Reset is asserted and released only there, and the select inputs are held high while it is low. Several selects may be low at the same edge in the pseudo-random phase. Any low effective select counts as an access, so this is legal stimulus and not a violation.

// File: rtl/cmd_reg_pkg.sv
package cmd_reg_pkg;
  parameter int unsigned ADDR_W = 16;
  parameter int unsigned BA_W   = 3;
  parameter int unsigned CS_W   = 4;
  parameter int unsigned CKE_W  = 2;
  parameter int unsigned ODT_W  = 2;
  // selects that gate in both modes
  localparam int unsigned BASE_CS_W = CS_W / 2;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [BA_W-1:0]   ba;
    logic              ras_n;
    logic              cas_n;
    logic              we_n;
  } cmd_t;

  typedef struct packed {
    logic [CKE_W-1:0] cke;
    logic [ODT_W-1:0] odt;
  } ctl_t;
endpackage

// File: rtl/cs_select_dec.sv
module cs_select_dec
  import cmd_reg_pkg::*;
(
  input  logic            quad_en_i,
  input  logic [CS_W-1:0] cs_n_i,
  output logic [CS_W-1:0] eff_cs_n_o,
  output logic            hit_o
);
  for (genvar i = 0; i < CS_W; i++) begin : g_sel
    if (i < BASE_CS_W) begin : g_base
      assign eff_cs_n_o[i] = cs_n_i[i];
    end else begin : g_quad
      assign eff_cs_n_o[i] = cs_n_i[i] | ~quad_en_i;
    end
  end

  assign hit_o = ~&eff_cs_n_o;
endmodule

// File: rtl/cmd_hold_reg.sv
module cmd_hold_reg
  import cmd_reg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  cmd_t cmd_i,
  output cmd_t cmd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_o <= '0;
    else if (load_i) cmd_o <= cmd_i;
  end

  a_r3_capture_on_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cmd_o == $past(cmd_i));

  a_r4_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cmd_o));
endmodule

// File: rtl/grp_drive.sv
module grp_drive
  import cmd_reg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            live_i,
  input  logic            en_i,
  input  cmd_t            cmd_i,
  input  logic [CS_W-1:0] cs_n_i,
  input  ctl_t            ctl_i,
  output logic            oe_o,
  output cmd_t            cmd_o,
  output logic [CS_W-1:0] cs_n_o,
  output ctl_t            ctl_o
);
  logic drive;
  assign drive  = live_i & en_i;
  assign oe_o   = drive;
  assign cmd_o  = drive ? cmd_i  : '0;
  assign cs_n_o = drive ? cs_n_i : '0;
  assign ctl_o  = drive ? ctl_i  : '0;

  a_r9_group_off_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!oe_o && cmd_o == '0 && cs_n_o == '0 && ctl_o == '0));
endmodule

// File: rtl/cs_gated_cmd_reg.sv
module cs_gated_cmd_reg
  import cmd_reg_pkg::*;
#(
  parameter int unsigned NGRP = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        quad_cs_en_i,
  input  logic [NGRP-1:0]             grp_en_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [BA_W-1:0]             ba_i,
  input  logic                        ras_n_i,
  input  logic                        cas_n_i,
  input  logic                        we_n_i,
  input  logic [CS_W-1:0]             cs_n_i,
  input  logic [CKE_W-1:0]            cke_i,
  input  logic [ODT_W-1:0]            odt_i,
  output logic [NGRP-1:0]             q_oe_o,
  output logic [NGRP-1:0][ADDR_W-1:0] q_addr_o,
  output logic [NGRP-1:0][BA_W-1:0]   q_ba_o,
  output logic [NGRP-1:0]             q_ras_n_o,
  output logic [NGRP-1:0]             q_cas_n_o,
  output logic [NGRP-1:0]             q_we_n_o,
  output logic [NGRP-1:0][CS_W-1:0]   q_cs_n_o,
  output logic [NGRP-1:0][CKE_W-1:0]  q_cke_o,
  output logic [NGRP-1:0][ODT_W-1:0]  q_odt_o
);
  logic [CS_W-1:0] eff_cs_n;
  logic            cs_hit;
  cmd_t            cmd_d, cmd_q;
  ctl_t            ctl_q;
  logic [CS_W-1:0] cs_q;
  logic            seen_q;   // first access registered
  logic            live_q;   // outputs driven since reset release

  cs_select_dec i_dec (
    .quad_en_i  (quad_cs_en_i),
    .cs_n_i     (cs_n_i),
    .eff_cs_n_o (eff_cs_n),
    .hit_o      (cs_hit)
  );

  assign cmd_d = '{addr: addr_i, ba: ba_i, ras_n: ras_n_i, cas_n: cas_n_i, we_n: we_n_i};

  cmd_hold_reg i_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cs_hit),
    .cmd_i  (cmd_d),
    .cmd_o  (cmd_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      live_q <= 1'b0;
      cs_q   <= '0;
      ctl_q  <= '0;
    end else begin
      live_q <= 1'b1;
      seen_q <= seen_q | cs_hit;
      ctl_q  <= '{cke: cke_i, odt: odt_i};
      // selects stay low until the first access
      if (cs_hit || seen_q) cs_q <= eff_cs_n;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    cmd_t gcmd;
    ctl_t gctl;
    grp_drive i_drv (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .live_i (live_q),
      .en_i   (grp_en_i[g]),
      .cmd_i  (cmd_q),
      .cs_n_i (cs_q),
      .ctl_i  (ctl_q),
      .oe_o   (q_oe_o[g]),
      .cmd_o  (gcmd),
      .cs_n_o (q_cs_n_o[g]),
      .ctl_o  (gctl)
    );
    assign q_addr_o[g]  = gcmd.addr;
    assign q_ba_o[g]    = gcmd.ba;
    assign q_ras_n_o[g] = gcmd.ras_n;
    assign q_cas_n_o[g] = gcmd.cas_n;
    assign q_we_n_o[g]  = gcmd.we_n;
    assign q_cke_o[g]   = gctl.cke;
    assign q_odt_o[g]   = gctl.odt;

    if (g > 0) begin : g_cmp
      a_r10_groups_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grp_en_i[0] && grp_en_i[g]) |->
          (q_addr_o[g] == q_addr_o[0] && q_ba_o[g] == q_ba_o[0] &&
           q_cs_n_o[g] == q_cs_n_o[0] && q_cke_o[g] == q_cke_o[0] &&
           q_odt_o[g] == q_odt_o[0] && q_ras_n_o[g] == q_ras_n_o[0]));
    end
  end

  a_r1_reset_off: assert property (@(posedge clk_i)
    !rst_ni |-> q_oe_o == '0);

  a_r2_low_until_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (cmd_q == '0 && cs_q == '0));

  a_r5_ctl_every_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && grp_en_i[0]) |=> (!grp_en_i[0] || q_cke_o[0] == $past(cke_i)));

  a_r6_upper_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!quad_cs_en_i && (cs_hit || seen_q)) |=> &cs_q[CS_W-1:BASE_CS_W]);

  a_r7_upper_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quad_cs_en_i && !cs_n_i[CS_W-1]) |=> (seen_q && !cs_q[CS_W-1]));
endmodule

// File: tb/test_cs_gated_cmd_reg.sv
`timescale 1ns/1ps
module test_cs_gated_cmd_reg;
  import cmd_reg_pkg::*;
  localparam int unsigned NGRP = 2;
  localparam int unsigned GW = 1 + $bits(cmd_t) + CS_W + $bits(ctl_t);

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic quad_en = 1'b0;
  logic [NGRP-1:0] grp_en = '1;
  cmd_t cmd_in = '0;
  logic [CS_W-1:0] cs_in = '1;
  ctl_t ctl_in = '0;

  logic [NGRP-1:0]             q_oe;
  logic [NGRP-1:0][ADDR_W-1:0] q_addr;
  logic [NGRP-1:0][BA_W-1:0]   q_ba;
  logic [NGRP-1:0]             q_ras, q_cas, q_we;
  logic [NGRP-1:0][CS_W-1:0]   q_cs;
  logic [NGRP-1:0][CKE_W-1:0]  q_cke;
  logic [NGRP-1:0][ODT_W-1:0]  q_odt;

  always #2.5 clk = ~clk;

  cs_gated_cmd_reg #(.NGRP(NGRP)) i_cs_gated_cmd_reg (
    .clk_i(clk), .rst_ni(rst_ni), .quad_cs_en_i(quad_en), .grp_en_i(grp_en),
    .addr_i(cmd_in.addr), .ba_i(cmd_in.ba), .ras_n_i(cmd_in.ras_n),
    .cas_n_i(cmd_in.cas_n), .we_n_i(cmd_in.we_n), .cs_n_i(cs_in),
    .cke_i(ctl_in.cke), .odt_i(ctl_in.odt),
    .q_oe_o(q_oe), .q_addr_o(q_addr), .q_ba_o(q_ba), .q_ras_n_o(q_ras),
    .q_cas_n_o(q_cas), .q_we_n_o(q_we), .q_cs_n_o(q_cs), .q_cke_o(q_cke),
    .q_odt_o(q_odt)
  );

  // reference model
  logic m_seen = 1'b0, m_live = 1'b0;
  cmd_t m_cmd = '0;
  logic [CS_W-1:0] m_cs = '0;
  ctl_t m_ctl = '0;

  logic [NGRP-1:0][GW-1:0] exp_q[$];
  string tag_q[$];
  int n_tests = 0, n_fail = 0;

  function automatic logic [NGRP-1:0][GW-1:0] act_vec();
    logic [NGRP-1:0][GW-1:0] v;
    for (int g = 0; g < NGRP; g++)
      v[g] = {q_oe[g], q_addr[g], q_ba[g], q_ras[g], q_cas[g], q_we[g],
              q_cs[g], q_cke[g], q_odt[g]};
    return v;
  endfunction

  function automatic logic [NGRP-1:0][GW-1:0] model_vec();
    logic [NGRP-1:0][GW-1:0] v;
    for (int g = 0; g < NGRP; g++)
      v[g] = (m_live && grp_en[g]) ? {1'b1, m_cmd, m_cs, m_ctl} : '0;
    return v;
  endfunction

  task automatic check_now(input string tag, input logic [NGRP-1:0][GW-1:0] e);
    logic [NGRP-1:0][GW-1:0] a;
    a = act_vec();
    n_tests++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, a, e);
    end
  endtask

  // driver: apply on falling edge, push what must show after the next rising edge
  task automatic step(input string tag, input logic [CS_W-1:0] cs, input cmd_t c,
                      input ctl_t k, input logic quad, input logic [NGRP-1:0] en);
    logic [CS_W-1:0] eff;
    logic hit;
    @(negedge clk);
    cs_in = cs; cmd_in = c; ctl_in = k; quad_en = quad; grp_en = en;
    eff = cs;
    if (!quad) eff[CS_W-1:BASE_CS_W] = '1;
    hit = ~&eff;
    if (hit) m_cmd = c;
    if (hit || m_seen) m_cs = eff;
    m_seen = m_seen | hit;
    m_ctl = k;
    m_live = 1'b1;
    exp_q.push_back(model_vec());
    tag_q.push_back(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    cs_in = '1; ctl_in = '0; grp_en = '1;
    rst_ni = 1'b0;
    m_seen = 1'b0; m_live = 1'b0; m_cmd = '0; m_cs = '0; m_ctl = '0;
    #1 check_now("R1", '0);
    repeat (2) @(posedge clk);
    #1 check_now("R1", '0);
    @(negedge clk);
    rst_ni = 1'b1;
    m_live = 1'b1;
    exp_q.push_back(model_vec());
    tag_q.push_back("R2");
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check_now(tag_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic cmd_t mk(input logic [ADDR_W-1:0] a, input logic [BA_W-1:0] b,
                              input logic [2:0] s);
    return '{addr: a, ba: b, ras_n: s[2], cas_n: s[1], we_n: s[0]};
  endfunction

  initial begin
    logic [31:0] lfsr;
    #1 rst_ni = 1'b0;
    #1 check_now("R1", '0);
    repeat (2) @(posedge clk);
    #1 check_now("R1", '0);
    @(negedge clk);
    rst_ni = 1'b1;
    m_live = 1'b1;
    exp_q.push_back(model_vec());
    tag_q.push_back("R2");

    // idle: outputs low, ungated controls still follow
    step("R2", 4'b1111, mk(16'hbeef, 3'd5, 3'b010), '{cke: 2'b11, odt: 2'b01}, 1'b0, 2'b11);
    step("R5", 4'b1111, mk(16'h1234, 3'd2, 3'b101), '{cke: 2'b10, odt: 2'b10}, 1'b0, 2'b11);
    // upper select with quad mode off: ignored
    step("R6", 4'b1011, mk(16'hdead, 3'd7, 3'b001), '{cke: 2'b01, odt: 2'b11}, 1'b0, 2'b11);
    step("R6", 4'b0111, mk(16'hdead, 3'd7, 3'b001), '{cke: 2'b01, odt: 2'b11}, 1'b0, 2'b11);
    // first access on select 0
    step("R3", 4'b1110, mk(16'ha5a5, 3'd3, 3'b011), '{cke: 2'b11, odt: 2'b00}, 1'b0, 2'b11);
    // idle with changing bus: hold
    step("R4", 4'b1111, mk(16'h0f0f, 3'd1, 3'b100), '{cke: 2'b00, odt: 2'b01}, 1'b0, 2'b11);
    step("R4", 4'b0011, mk(16'hffff, 3'd6, 3'b111), '{cke: 2'b10, odt: 2'b11}, 1'b0, 2'b11);
    step("R8", 4'b1101, mk(16'h5a5a, 3'd4, 3'b110), '{cke: 2'b11, odt: 2'b10}, 1'b0, 2'b11);
    // quad mode on: upper selects gate
    step("R7", 4'b0111, mk(16'h3c3c, 3'd0, 3'b000), '{cke: 2'b01, odt: 2'b00}, 1'b1, 2'b11);
    step("R7", 4'b1011, mk(16'hc3c3, 3'd7, 3'b101), '{cke: 2'b01, odt: 2'b00}, 1'b1, 2'b11);
    step("R8", 4'b1111, mk(16'h7777, 3'd2, 3'b010), '{cke: 2'b00, odt: 2'b00}, 1'b1, 2'b11);
    // back to two-select mode
    step("R6", 4'b0111, mk(16'h8888, 3'd1, 3'b011), '{cke: 2'b10, odt: 2'b01}, 1'b0, 2'b11);
    step("R6", 4'b0110, mk(16'h9999, 3'd5, 3'b001), '{cke: 2'b10, odt: 2'b01}, 1'b0, 2'b11);
    // group enables
    step("R9", 4'b1110, mk(16'h4242, 3'd3, 3'b110), '{cke: 2'b11, odt: 2'b11}, 1'b0, 2'b01);
    step("R9", 4'b1111, mk(16'h4343, 3'd3, 3'b110), '{cke: 2'b01, odt: 2'b10}, 1'b0, 2'b10);
    step("R9", 4'b1101, mk(16'h4444, 3'd6, 3'b100), '{cke: 2'b10, odt: 2'b01}, 1'b0, 2'b00);
    step("R10", 4'b1111, mk(16'h0000, 3'd0, 3'b000), '{cke: 2'b11, odt: 2'b00}, 1'b0, 2'b11);

    // reset in mid-run, then low until first access again
    do_reset();
    step("R2", 4'b1111, mk(16'h6666, 3'd2, 3'b111), '{cke: 2'b01, odt: 2'b01}, 1'b1, 2'b11);
    step("R3", 4'b1011, mk(16'h1357, 3'd4, 3'b010), '{cke: 2'b10, odt: 2'b10}, 1'b1, 2'b11);

    // pseudo-random traffic
    lfsr = 32'hace1_2468;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R3", (lfsr[3:0] == 4'b0) ? 4'b1111 : lfsr[7:4] | {2'b00, lfsr[9], 1'b0},
           mk(lfsr[31:16], lfsr[12:10], lfsr[15:13]),
           '{cke: lfsr[17:16], odt: lfsr[19:18]}, lfsr[20], {1'b1, lfsr[22] | lfsr[23]});
    end
    repeat (3) @(posedge clk);
    #2;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule